// File: doc/BRIEF.md
# Two-Thread Partitioned Reorder Buffer

This block tracks micro-operations from two hardware threads between dispatch and retirement. Each thread owns a fixed half of the entry storage and runs that half as a circular queue. A thread allocates entries in program order through its own allocate port and receives the entry index. Execution units later mark entries finished through one shared completion port. Retirement drains finished entries from the head of each queue in program order.

Only one thread retires in any cycle, and it retires up to three consecutive finished head entries. When both threads have a finished head entry, the winner alternates from one cycle to the next. When only one thread has a finished head entry, that thread gets every slot. An entry completed with its fault flag set stops its thread at that entry and raises a per-thread exception. A per-thread flush input then empties that thread's half.

Top module: `rob_two_thread`

## Requirements
- R1: After reset both allocate ports are ready, no retirement slot is valid and both exception outputs are low.
- R2: Each thread owns 16 entries. The index returned for a thread is {thread bit as MSB, 4-bit slot}, and slots are handed out in order 0, 1, 2 and so on, wrapping after 15. A thread's allocate port goes not-ready with 16 entries outstanding, whatever the state of the other half, and an allocate request made while not-ready is ignored.
- R3: An entry retires only after it has been completed. Within a thread, entries retire in allocation order, and retirement stops at the first entry that is not complete. On the completion port, bit 4 of the index selects the thread and bits 3:0 select the slot.
- R4: At most three entries retire per cycle. Valid slots are filled from slot 0 upward with no gaps. Each valid slot carries the index, destination and result of its entry.
- R5: When both threads have a completed head entry, the retiring thread is the one that did not retire in the most recent retiring cycle.
- R6: When only one thread has a completed head entry, that thread retires, even if the other thread is stalled or holds an exception.
- R7: An entry completed with the fault flag set never retires. Entries ahead of it still retire. Once it reaches the head, retirement of that thread stops and that thread's exception output is high.
- R8: A flush of a thread empties its half. In the following cycle that thread's exception is low, its allocate port is ready and its next slot is 0. The other thread is unaffected.
- R9: Retiring entries frees them, so a full thread's allocate port becomes ready again after it retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 2 | Allocate request, one bit per thread |
| alloc_dest_i | input | 2x5 | Destination field for each thread's allocation |
| alloc_ready_o | output | 2 | Thread half has a free entry |
| alloc_idx_o | output | 2x5 | Index the next allocation of each thread will get |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_idx_i | input | 5 | Entry being completed |
| cmpl_result_i | input | 16 | Result tag stored into the entry |
| cmpl_fault_i | input | 1 | Entry completed with a fault |
| flush_i | input | 2 | Empty the half of a thread |
| exc_o | output | 2 | Faulted entry at the head of a thread |
| ret_valid_o | output | 3 | Retirement slot valid |
| ret_thread_o | output | 3 | Thread of each retirement slot |
| ret_idx_o | output | 3x5 | Index of each retiring entry |
| ret_dest_o | output | 3x5 | Destination of each retiring entry |
| ret_result_o | output | 3x16 | Result of each retiring entry |

## Verification
The assertions assume that the completion port only names entries that are outstanding and not yet completed. They also assume that no completion targets the slot being allocated in the same cycle, or a thread being flushed in that cycle. The random stimulus picks completion targets only from entries between a thread's head and tail that the bench model still holds as incomplete, and it skips completions to a thread it is flushing. The allocation slot is always the tail, which lies outside that range. Allocation requests are driven freely, including at full, because the block must ignore them there.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  localparam int unsigned NTHR = 2;
  typedef enum logic {THR_A = 1'b0, THR_B = 1'b1} thr_e;
endpackage

// File: rtl/rob_half.sv
`timescale 1ns/1ps
// One thread's share of the buffer: circular queue of entries (DEPTH power of two).
module rob_half #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned RW     = 3,
  parameter int unsigned DEST_W = 5,
  parameter int unsigned RES_W  = 16,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned RCW   = $clog2(RW + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic                           alloc_i,
  input  logic [DEST_W-1:0]              alloc_dest_i,
  output logic                           full_o,
  output logic [PW-1:0]                  tail_o,
  input  logic                           cmpl_i,
  input  logic [PW-1:0]                  cmpl_idx_i,
  input  logic [RES_W-1:0]               cmpl_res_i,
  input  logic                           cmpl_fault_i,
  input  logic [RCW-1:0]                 ret_cnt_i,
  output logic [RCW-1:0]                 rdy_cnt_o,
  output logic                           fault_o,
  output logic [RW-1:0][PW-1:0]          slot_idx_o,
  output logic [RW-1:0][DEST_W-1:0]      slot_dest_o,
  output logic [RW-1:0][RES_W-1:0]       slot_res_o
);
  logic [PW-1:0]                 head_q, tail_q;
  logic [CW-1:0]                 count_q;
  logic [DEPTH-1:0]              done_q, fault_q;
  logic [DEPTH-1:0][DEST_W-1:0]  dest_q;
  logic [DEPTH-1:0][RES_W-1:0]   res_q;
  logic                          alloc_fire;
  logic [RW-1:0][PW-1:0]         sidx;
  logic [RCW-1:0]                rdy;
  logic                          stop;

  assign full_o     = (count_q == CW'(DEPTH));
  assign tail_o     = tail_q;
  assign alloc_fire = alloc_i && !full_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      done_q  <= '0;
      fault_q <= '0;
    end else if (flush_i) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc_fire) begin
        tail_q          <= tail_q + 1'b1;
        done_q[tail_q]  <= 1'b0;
        fault_q[tail_q] <= 1'b0;
      end
      if (cmpl_i) begin
        done_q[cmpl_idx_i]  <= 1'b1;
        fault_q[cmpl_idx_i] <= cmpl_fault_i;
      end
      head_q  <= head_q + PW'(ret_cnt_i);
      count_q <= count_q + CW'(alloc_fire) - CW'(ret_cnt_i);
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk_i) begin
    if (alloc_fire) dest_q[tail_q] <= alloc_dest_i;
    if (cmpl_i && !flush_i) res_q[cmpl_idx_i] <= cmpl_res_i;
  end

  // count consecutive clean completions from the head, stop at first gap or fault
  always_comb begin
    rdy  = '0;
    stop = 1'b0;
    for (int k = 0; k < RW; k++) begin
      sidx[k] = head_q + PW'(k);
      if (!stop && (CW'(k) < count_q) && done_q[sidx[k]] && !fault_q[sidx[k]])
        rdy = rdy + 1'b1;
      else
        stop = 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < RW; k++) begin
      slot_idx_o[k]  = sidx[k];
      slot_dest_o[k] = dest_q[sidx[k]];
      slot_res_o[k]  = res_q[sidx[k]];
    end
  end

  assign rdy_cnt_o = rdy;
  assign fault_o   = (count_q != '0) && done_q[head_q] && fault_q[head_q];
endmodule

// File: rtl/rob_arb.sv
`timescale 1ns/1ps
// Picks the retiring thread: alternate when both ready, else the ready one.
module rob_arb
  import rob_pkg::*;
#(
  parameter int unsigned RCW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RCW-1:0] rdy0_i,
  input  logic [RCW-1:0] rdy1_i,
  output logic           go_o,
  output logic           sel_o,
  output logic [RCW-1:0] ret0_o,
  output logic [RCW-1:0] ret1_o
);
  thr_e last_q;
  thr_e sel;
  logic has0, has1;

  assign has0 = (rdy0_i != '0);
  assign has1 = (rdy1_i != '0);

  always_comb begin
    if (has0 && has1) sel = (last_q == THR_A) ? THR_B : THR_A;
    else if (has0)    sel = THR_A;
    else              sel = THR_B;
  end

  assign go_o   = has0 || has1;
  assign sel_o  = (sel == THR_B);
  assign ret0_o = (go_o && sel == THR_A) ? rdy0_i : '0;
  assign ret1_o = (go_o && sel == THR_B) ? rdy1_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_q <= THR_B;
    else if (go_o) last_q <= sel;
  end
endmodule

// File: rtl/rob_two_thread.sv
`timescale 1ns/1ps
module rob_two_thread
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned RW     = 3,
  parameter int unsigned DEST_W = 5,
  parameter int unsigned RES_W  = 16,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned IDX_W = PW + 1,
  localparam int unsigned RCW   = $clog2(RW + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NTHR-1:0]               alloc_valid_i,
  input  logic [NTHR-1:0][DEST_W-1:0]   alloc_dest_i,
  output logic [NTHR-1:0]               alloc_ready_o,
  output logic [NTHR-1:0][IDX_W-1:0]    alloc_idx_o,
  input  logic                          cmpl_valid_i,
  input  logic [IDX_W-1:0]              cmpl_idx_i,
  input  logic [RES_W-1:0]              cmpl_result_i,
  input  logic                          cmpl_fault_i,
  input  logic [NTHR-1:0]               flush_i,
  output logic [NTHR-1:0]               exc_o,
  output logic [RW-1:0]                 ret_valid_o,
  output logic [RW-1:0]                 ret_thread_o,
  output logic [RW-1:0][IDX_W-1:0]      ret_idx_o,
  output logic [RW-1:0][DEST_W-1:0]     ret_dest_o,
  output logic [RW-1:0][RES_W-1:0]      ret_result_o
);
  logic [NTHR-1:0]                        full;
  logic [NTHR-1:0][PW-1:0]                tail;
  logic [NTHR-1:0][RCW-1:0]               rdy_cnt;
  logic [NTHR-1:0][RCW-1:0]               ret_cnt;
  logic [NTHR-1:0][RW-1:0][PW-1:0]        slot_idx;
  logic [NTHR-1:0][RW-1:0][DEST_W-1:0]    slot_dest;
  logic [NTHR-1:0][RW-1:0][RES_W-1:0]     slot_res;
  logic                                   go, sel;
  logic [RCW-1:0]                         sel_cnt;
  logic                                   vld;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    rob_half #(
      .DEPTH(DEPTH), .RW(RW), .DEST_W(DEST_W), .RES_W(RES_W)
    ) u_half (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .flush_i      (flush_i[t]),
      .alloc_i      (alloc_valid_i[t]),
      .alloc_dest_i (alloc_dest_i[t]),
      .full_o       (full[t]),
      .tail_o       (tail[t]),
      .cmpl_i       (cmpl_valid_i && (cmpl_idx_i[IDX_W-1] == 1'(t))),
      .cmpl_idx_i   (cmpl_idx_i[PW-1:0]),
      .cmpl_res_i   (cmpl_result_i),
      .cmpl_fault_i (cmpl_fault_i),
      .ret_cnt_i    (ret_cnt[t]),
      .rdy_cnt_o    (rdy_cnt[t]),
      .fault_o      (exc_o[t]),
      .slot_idx_o   (slot_idx[t]),
      .slot_dest_o  (slot_dest[t]),
      .slot_res_o   (slot_res[t])
    );
    assign alloc_ready_o[t] = ~full[t];
    assign alloc_idx_o[t]   = {1'(t), tail[t]};
  end

  rob_arb #(.RCW(RCW)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rdy0_i (rdy_cnt[0]),
    .rdy1_i (rdy_cnt[1]),
    .go_o   (go),
    .sel_o  (sel),
    .ret0_o (ret_cnt[0]),
    .ret1_o (ret_cnt[1])
  );

  assign sel_cnt = rdy_cnt[sel];

  always_comb begin
    for (int k = 0; k < RW; k++) begin
      vld             = go && (RCW'(k) < sel_cnt);
      ret_valid_o[k]  = vld;
      ret_thread_o[k] = vld & sel;
      ret_idx_o[k]    = {sel, slot_idx[sel][k]};
      ret_dest_o[k]   = slot_dest[sel][k];
      ret_result_o[k] = slot_res[sel][k];
    end
  end
endmodule

// File: rtl/rob_checker.sv
`timescale 1ns/1ps
module rob_checker #(
  parameter int unsigned RW    = 3,
  parameter int unsigned PW    = 4,
  parameter int unsigned RCW   = 2,
  localparam int unsigned IDX_W = PW + 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [1:0]               flush_i,
  input logic [1:0]               exc_o,
  input logic [1:0]               alloc_ready_o,
  input logic [RW-1:0]            ret_valid_o,
  input logic [RW-1:0]            ret_thread_o,
  input logic [RW-1:0][IDX_W-1:0] ret_idx_o,
  input logic [1:0][RCW-1:0]      rdy_cnt_i
);
  assert_contig_slots_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ret_valid_o & (ret_valid_o + 1'b1)) == '0));

  for (genvar k = 1; k < RW; k++) begin : g_ord
    assert_seq_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_valid_o[k] |-> (ret_idx_o[k][IDX_W-1] == ret_idx_o[k-1][IDX_W-1]) &&
                         (ret_idx_o[k][PW-1:0] == ret_idx_o[k-1][PW-1:0] + 1'b1));
  end

  assert_alternate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdy_cnt_i[0] != '0) && (rdy_cnt_i[1] != '0) && $past(ret_valid_o[0]))
      |-> (ret_thread_o[0] != $past(ret_thread_o[0])));

  assert_full_bandwidth_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdy_cnt_i[0] != '0) || (rdy_cnt_i[1] != '0)) |-> ret_valid_o[0]);

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assert_fault_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_o[t] |-> !(ret_valid_o[0] && (ret_thread_o[0] == 1'(t))));

    assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(flush_i[t]) |-> (alloc_ready_o[t] && !exc_o[t]));
  end
endmodule

bind rob_two_thread rob_checker #(.RW(RW), .PW(PW), .RCW(RCW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .exc_o         (exc_o),
  .alloc_ready_o (alloc_ready_o),
  .ret_valid_o   (ret_valid_o),
  .ret_thread_o  (ret_thread_o),
  .ret_idx_o     (ret_idx_o),
  .rdy_cnt_i     (rdy_cnt)
);

// File: tb/rob_two_thread_bench.sv
`timescale 1ns/1ps
module rob_two_thread_bench;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]        alloc_v = '0;
  logic [1:0][4:0]   alloc_dest = '0;
  logic [1:0]        alloc_ready;
  logic [1:0][4:0]   alloc_idx;
  logic              cmpl_v = 1'b0;
  logic [4:0]        cmpl_idx = '0;
  logic [15:0]       cmpl_res = '0;
  logic              cmpl_fault = 1'b0;
  logic [1:0]        flush = '0;
  logic [1:0]        exc;
  logic [2:0]        ret_valid, ret_thread;
  logic [2:0][4:0]   ret_idx, ret_dest;
  logic [2:0][15:0]  ret_result;

  rob_two_thread u_rob_two_thread (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_v), .alloc_dest_i(alloc_dest),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .cmpl_valid_i(cmpl_v), .cmpl_idx_i(cmpl_idx),
    .cmpl_result_i(cmpl_res), .cmpl_fault_i(cmpl_fault),
    .flush_i(flush), .exc_o(exc),
    .ret_valid_o(ret_valid), .ret_thread_o(ret_thread),
    .ret_idx_o(ret_idx), .ret_dest_o(ret_dest), .ret_result_o(ret_result)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  bit          m_done [2][D];
  bit          m_fault[2][D];
  logic [4:0]  m_dest [2][D];
  logic [15:0] m_res  [2][D];
  int m_head[2], m_tail[2], m_cnt[2];
  int m_last = 1;

  task automatic chk_eq(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rc(int t);
    int n = 0;
    for (int k = 0; k < 3; k++) begin
      int s = (m_head[t] + k) % D;
      if (k < m_cnt[t] && m_done[t][s] && !m_fault[t][s]) n++;
      else break;
    end
    return n;
  endfunction

  function automatic bit m_exc(int t);
    return m_cnt[t] > 0 && m_done[t][m_head[t]] && m_fault[t][m_head[t]];
  endfunction

  task automatic pick(output int sel, output int n);
    int r0 = rc(0);
    int r1 = rc(1);
    if (r0 > 0 && r1 > 0) sel = 1 - m_last;
    else if (r0 > 0)      sel = 0;
    else                  sel = 1;
    n = (sel == 1) ? r1 : r0;
  endtask

  task automatic check_outputs();
    int sel, n;
    pick(sel, n);
    for (int t = 0; t < 2; t++) begin
      chk_eq("R2 alloc_ready", 64'(alloc_ready[t]), 64'(m_cnt[t] < D));
      chk_eq("R2 alloc_idx", 64'(alloc_idx[t]), 64'(t * D + m_tail[t]));
      chk_eq("R7 exception", 64'(exc[t]), 64'(m_exc(t)));
    end
    chk_eq("R4 ret_valid", 64'(ret_valid), 64'((1 << n) - 1));
    for (int k = 0; k < n; k++) begin
      int s = (m_head[sel] + k) % D;
      chk_eq("R5 R6 ret_thread", 64'(ret_thread[k]), 64'(sel));
      chk_eq("R3 ret_idx order", 64'(ret_idx[k]), 64'(sel * D + s));
      chk_eq("R4 ret_dest", 64'(ret_dest[k]), 64'(m_dest[sel][s]));
      chk_eq("R4 ret_result", 64'(ret_result[k]), 64'(m_res[sel][s]));
    end
  endtask

  task automatic step();
    int sel, n;
    check_outputs();
    pick(sel, n);
    @(posedge clk);
    for (int t = 0; t < 2; t++) begin
      if (flush[t]) begin
        m_head[t] = 0; m_tail[t] = 0; m_cnt[t] = 0;
      end else begin
        int r = (n > 0 && sel == t) ? n : 0;
        bit a = alloc_v[t] && (m_cnt[t] < D);
        if (a) begin
          m_done[t][m_tail[t]]  = 1'b0;
          m_fault[t][m_tail[t]] = 1'b0;
          m_dest[t][m_tail[t]]  = alloc_dest[t];
          m_tail[t] = (m_tail[t] + 1) % D;
        end
        if (cmpl_v && int'(cmpl_idx[4]) == t) begin
          m_done[t][cmpl_idx[3:0]]  = 1'b1;
          m_fault[t][cmpl_idx[3:0]] = cmpl_fault;
          m_res[t][cmpl_idx[3:0]]   = cmpl_res;
        end
        m_head[t] = (m_head[t] + r) % D;
        m_cnt[t]  = m_cnt[t] + int'(a) - r;
      end
    end
    if (n > 0) m_last = sel;
    @(negedge clk);
    alloc_v = '0; cmpl_v = 1'b0; cmpl_fault = 1'b0; flush = '0;
  endtask

  task automatic do_alloc(int t, int d);
    alloc_v[t] = 1'b1; alloc_dest[t] = 5'(d); step();
  endtask

  task automatic do_cmpl(int idx, int res, bit f);
    cmpl_v = 1'b1; cmpl_idx = 5'(idx); cmpl_res = 16'(res); cmpl_fault = f; step();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    for (int t = 0; t < 2; t++) begin
      m_head[t] = 0; m_tail[t] = 0; m_cnt[t] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_eq("R1 alloc_ready", 64'(alloc_ready), 64'h3);
    chk_eq("R1 ret_valid", 64'(ret_valid), 64'h0);
    chk_eq("R1 exc", 64'(exc), 64'h0);

    // R2 fill thread 0, thread 1 stays ready
    for (int k = 0; k < D; k++) begin
      chk_eq("R2 sequential index", 64'(alloc_idx[0]), 64'(k));
      do_alloc(0, k);
    end
    chk_eq("R2 full half only", 64'(alloc_ready), 64'h2);
    do_alloc(0, 9);
    chk_eq("R2 alloc at full ignored", 64'(alloc_ready), 64'h2);

    // R3 out-of-order completion, in-order retirement
    do_cmpl(2, 16'hA002, 1'b0);
    do_cmpl(1, 16'hA001, 1'b0);
    chk_eq("R3 gap at head blocks", 64'(ret_valid), 64'h0);
    do_cmpl(0, 16'hA000, 1'b0);
    chk_eq("R4 three slots", 64'(ret_valid), 64'h7);
    chk_eq("R3 slot2 idx", 64'(ret_idx[2]), 64'd2);
    chk_eq("R4 slot2 dest", 64'(ret_dest[2]), 64'd2);
    chk_eq("R4 slot0 result", 64'(ret_result[0]), 64'hA000);
    step();
    chk_eq("R3 stop at incomplete", 64'(ret_valid), 64'h0);
    chk_eq("R9 freed entries", 64'(alloc_ready[0]), 64'h1);

    // R5 / R6 arbitration
    for (int k = 0; k < 4; k++) do_alloc(1, 20 + k);
    do_cmpl(19, 16'hB003, 1'b0);
    do_cmpl(18, 16'hB002, 1'b0);
    do_cmpl(17, 16'hB001, 1'b0);
    for (int k = 8; k >= 4; k--) do_cmpl(k, 16'hA000 + k, 1'b0);
    do_cmpl(16, 16'hB000, 1'b0);
    chk_eq("R6 lone thread takes all", 64'(ret_valid), 64'h7);
    chk_eq("R6 lone thread tag", 64'(ret_thread), 64'h7);
    do_cmpl(3, 16'hA003, 1'b0);
    chk_eq("R5 alternate to thread0", 64'(ret_thread[0]), 64'h0);
    chk_eq("R5 thread0 width", 64'(ret_valid), 64'h7);
    step();
    chk_eq("R5 alternate to thread1", 64'(ret_thread[0]), 64'h1);
    chk_eq("R5 thread1 single", 64'(ret_valid), 64'h1);
    step();
    chk_eq("R6 back-to-back thread0", 64'(ret_thread[0]), 64'h0);
    chk_eq("R6 back-to-back width", 64'(ret_valid), 64'h7);
    step();
    chk_eq("R3 drained", 64'(ret_valid), 64'h0);

    // R7 fault handling
    do_cmpl(10, 16'hF00D, 1'b1);
    do_cmpl(11, 16'hA00B, 1'b0);
    do_cmpl(9, 16'hA009, 1'b0);
    chk_eq("R7 entry before fault retires", 64'(ret_valid), 64'h1);
    chk_eq("R7 retiring idx", 64'(ret_idx[0]), 64'd9);
    step();
    chk_eq("R7 exception raised", 64'(exc), 64'h1);
    chk_eq("R7 retirement halted", 64'(ret_valid), 64'h0);
    do_alloc(1, 30);
    do_cmpl(20, 16'hB004, 1'b0);
    chk_eq("R6 other thread retires past exception", 64'(ret_thread[0]), 64'h1);
    chk_eq("R7 exception held", 64'(exc), 64'h1);

    // R8 flush
    flush[0] = 1'b1;
    step();
    chk_eq("R8 exception cleared", 64'(exc), 64'h0);
    chk_eq("R8 ready after flush", 64'(alloc_ready[0]), 64'h1);
    chk_eq("R8 slot restarts", 64'(alloc_idx[0]), 64'd0);
    chk_eq("R8 other thread kept", 64'(alloc_idx[1]), 64'd21);

    // random phase against the model
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int t = 0; t < 2; t++) begin
        alloc_v[t]    = ($urandom % 4) != 0;
        alloc_dest[t] = 5'($urandom);
        if (m_exc(t) && ($urandom % 4) == 0) flush[t] = 1'b1;
      end
      if (($urandom % 4) != 0) begin
        int t = int'($urandom % 2);
        if (m_cnt[t] > 0 && !flush[t]) begin
          int s = (m_head[t] + int'($urandom % 32'(m_cnt[t]))) % D;
          if (!m_done[t][s]) begin
            cmpl_v     = 1'b1;
            cmpl_idx   = 5'(t * D + s);
            cmpl_res   = 16'($urandom);
            cmpl_fault = ($urandom % 32) == 0;
          end
        end
      end
      step();
    end

    report();
    $finish;
  end
endmodule